// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds eight hardware semaphore flags that two independent ports, called left and right, share. Software on each side uses a flag to claim a shared resource. It writes a 0 to request the flag, then reads the flag back to learn whether the claim succeeded. It writes a 1 to give the flag up. At most one port owns a flag at any time. A request made while the other side holds the flag stays pending, and that port takes ownership when the holder releases the flag.

Each port has a chip select and a semaphore select, both active low, a read/write line, an output enable, two byte enables, an address bus and a 16-bit data bus. A port reaches the flags when its semaphore select is low and its chip select is high. The low three address bits pick the flag. A write is captured when the read/write line rises from 0 to 1 during a semaphore access, and only data bit 0 is used. A read returns that port's view of the flag on every data bit. The combination of chip select low, semaphore select low and any byte enable low is illegal: it changes no flag and raises a one-cycle error strobe.

All inputs are sampled on the rising edge of a single clock. The design is fully synchronous, with an active-low asynchronous reset.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset all eight flags are free, both ports read 1 (every data bit) on every flag, and both error strobes are low.
- R2: A write of data bit 0 = 0 is a request. If the other port does not own the flag, the writing port becomes owner at that clock edge. The owner then reads 0 and the other port reads 1.
- R3: The data output of a port shows the flag view replicated on all 16 bits when semaphore select = 0, chip select = 1, read/write = 1 and output enable = 0. In every other case the output is all zeros.
- R4: A request made while the other port owns the flag leaves the owner unchanged. The requester keeps reading 1 and its request stays pending.
- R5: A write of data bit 0 = 1 withdraws the port's request or ownership. If the other port has a pending request, ownership passes to it at the same clock edge.
- R6: If both ports request the same free flag at the same clock edge, the left port becomes owner and the right port's request stays pending.
- R7: A write takes effect only at a clock edge where read/write is 1, the previous sampled read/write was 0, and the semaphore access condition holds. Only address bits 2:0 select the flag. Address bits above 2, data bits 15:1 and the byte enables (while chip select = 1) are ignored. Flags are independent of one another.
- R8: The illegal access (chip select = 0, semaphore select = 0, either byte enable = 0) never changes a flag. The port's error output goes high for exactly one cycle, the cycle after the illegal condition is first sampled. With both byte enables high the combination is neither an access nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left chip select, active low (high for semaphore access) |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_rw | input | 1 | Left read (1) / write (0); write captured on 0-to-1 |
| l_oe_n | input | 1 | Left output enable, active low |
| l_be_n | input | 2 | Left byte enables, active low |
| l_addr | input | 13 | Left address; bits 2:0 pick the flag |
| l_din | input | 16 | Left write data; bit 0 used |
| l_dout | output | 16 | Left read data |
| l_err | output | 1 | Left illegal-access strobe |
| r_cs_n | input | 1 | Right chip select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_rw | input | 1 | Right read/write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_be_n | input | 2 | Right byte enables, active low |
| r_addr | input | 13 | Right address |
| r_din | input | 16 | Right write data |
| r_dout | output | 16 | Right read data |
| r_err | output | 1 | Right illegal-access strobe |

## Verification
The assertions assume that the ports' control lines are already synchronous to the clock and hold steady across each edge. The no-change rule for an illegal access is checked only while the other port makes no write, because a legal write from the opposite side may change flags in that same cycle. The stimulus changes every input on the falling edge. It holds each access for whole cycles and returns read/write to 1 between writes, so that every write produces exactly one rising edge.

// File: rtl/sem_flag_pkg.sv
package sem_flag_pkg;

  typedef struct packed {
    logic left;
    logic right;
  } owner_t;

  // Next owner of one flag from current ownership and updated requests.
  // A holder keeps the flag while its request stands; otherwise the left
  // request is served before the right one.
  function automatic owner_t pick_owner(input owner_t cur,
                                        input logic req_left,
                                        input logic req_right);
    owner_t nxt;
    nxt = '0;
    if (cur.left && req_left)        nxt.left  = 1'b1;
    else if (cur.right && req_right) nxt.right = 1'b1;
    else if (req_left)               nxt.left  = 1'b1;
    else if (req_right)              nxt.right = 1'b1;
    return nxt;
  endfunction

  // Request bit after a possible write: data bit 0 low means "request".
  function automatic logic next_req(input logic hit, input logic wbit,
                                    input logic req_now);
    return hit ? ~wbit : req_now;
  endfunction

endpackage

// File: rtl/sem_port_ctl.sv
module sem_port_ctl #(
  parameter int ADDR_W = 13,
  parameter int BE_W   = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sem_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic [BE_W-1:0]   be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit_in,
  output logic [SEL_W-1:0]  sel,
  output logic              wr_ev,
  output logic              wr_bit,
  output logic              rd_en,
  output logic              illegal,
  output logic              err
);
  logic sem_acc;
  logic rw_q;
  logic ill_q;

  assign sem_acc = !sem_n && cs_n;
  assign illegal = !sem_n && !cs_n && (be_n != {BE_W{1'b1}});
  assign rd_en   = sem_acc && rw && !oe_n;
  assign wr_ev   = sem_acc && rw && !rw_q;
  assign wr_bit  = wbit_in;
  assign sel     = addr[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q  <= 1'b1;
      ill_q <= 1'b0;
      err   <= 1'b0;
    end else begin
      rw_q  <= rw;
      ill_q <= illegal;
      err   <= illegal && !ill_q;
    end
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_l,
  input  logic bit_l,
  input  logic hit_r,
  input  logic bit_r,
  output logic own_l,
  output logic own_r
);
  logic   req_l, req_r;
  logic   nreq_l, nreq_r;
  owner_t cur, nxt;

  assign nreq_l = next_req(hit_l, bit_l, req_l);
  assign nreq_r = next_req(hit_r, bit_r, req_r);
  assign cur    = '{left: own_l, right: own_r};
  assign nxt    = pick_owner(cur, nreq_l, nreq_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l <= 1'b0;
      req_r <= 1'b0;
      own_l <= 1'b0;
      own_r <= 1'b0;
    end else begin
      req_l <= nreq_l;
      req_r <= nreq_r;
      own_l <= nxt.left;
      own_r <= nxt.right;
    end
  end
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                l_cs_n,
  input  logic                l_sem_n,
  input  logic                l_rw,
  input  logic                l_oe_n,
  input  logic [DATA_W/8-1:0] l_be_n,
  input  logic [ADDR_W-1:0]   l_addr,
  input  logic [DATA_W-1:0]   l_din,
  output logic [DATA_W-1:0]   l_dout,
  output logic                l_err,
  input  logic                r_cs_n,
  input  logic                r_sem_n,
  input  logic                r_rw,
  input  logic                r_oe_n,
  input  logic [DATA_W/8-1:0] r_be_n,
  input  logic [ADDR_W-1:0]   r_addr,
  input  logic [DATA_W-1:0]   r_din,
  output logic [DATA_W-1:0]   r_dout,
  output logic                r_err
);
  localparam int BE_W  = DATA_W / 8;
  localparam int SEL_W = $clog2(NUM_FLAGS);

  logic [SEL_W-1:0]     sel_l, sel_r;
  logic                 wev_l, wev_r, wbit_l, wbit_r;
  logic                 rd_l, rd_r, ill_l, ill_r;
  logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec;

  sem_port_ctl #(.ADDR_W(ADDR_W), .BE_W(BE_W), .SEL_W(SEL_W)) u_left (
    .clk(clk), .rst_n(rst_n), .cs_n(l_cs_n), .sem_n(l_sem_n), .rw(l_rw),
    .oe_n(l_oe_n), .be_n(l_be_n), .addr(l_addr), .wbit_in(l_din[0]),
    .sel(sel_l), .wr_ev(wev_l), .wr_bit(wbit_l), .rd_en(rd_l),
    .illegal(ill_l), .err(l_err));

  sem_port_ctl #(.ADDR_W(ADDR_W), .BE_W(BE_W), .SEL_W(SEL_W)) u_right (
    .clk(clk), .rst_n(rst_n), .cs_n(r_cs_n), .sem_n(r_sem_n), .rw(r_rw),
    .oe_n(r_oe_n), .be_n(r_be_n), .addr(r_addr), .wbit_in(r_din[0]),
    .sel(sel_r), .wr_ev(wev_r), .wr_bit(wbit_r), .rd_en(rd_r),
    .illegal(ill_r), .err(r_err));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .hit_l(wev_l && (sel_l == SEL_W'(i))), .bit_l(wbit_l),
      .hit_r(wev_r && (sel_r == SEL_W'(i))), .bit_r(wbit_r),
      .own_l(own_l_vec[i]), .own_r(own_r_vec[i]));
  end

  // A port reads 0 only for a flag it owns.
  assign l_dout = rd_l ? {DATA_W{~own_l_vec[sel_l]}} : '0;
  assign r_dout = rd_r ? {DATA_W{~own_r_vec[sel_r]}} : '0;
endmodule

// File: rtl/sem_flag_bank_chk.sv
module sem_flag_bank_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  parameter int SEL_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_FLAGS-1:0] own_l_vec,
  input logic [NUM_FLAGS-1:0] own_r_vec,
  input logic                 ill_l,
  input logic                 ill_r,
  input logic                 wev_l,
  input logic                 wev_r,
  input logic                 wbit_l,
  input logic                 wbit_r,
  input logic [SEL_W-1:0]     sel_l,
  input logic [SEL_W-1:0]     sel_r,
  input logic                 l_err,
  input logic                 r_err,
  input logic [DATA_W-1:0]    l_dout,
  input logic [DATA_W-1:0]    r_dout
);
  a_r1_reset_free: assert property (@(posedge clk)
    !rst_n |=> (own_l_vec == '0 && own_r_vec == '0));

  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l_vec & own_r_vec) == '0);

  a_r3_replicated_l: assert property (@(posedge clk) disable iff (!rst_n)
    (l_dout == '0) || (l_dout == '1));

  a_r3_replicated_r: assert property (@(posedge clk) disable iff (!rst_n)
    (r_dout == '0) || (r_dout == '1));

  a_r6_left_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (wev_l && wev_r && sel_l == sel_r && !wbit_l && !wbit_r &&
     !own_l_vec[sel_l] && !own_r_vec[sel_l]) |=> own_l_vec[$past(sel_l)]);

  a_r8_illegal_l_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_l && !wev_r) |=> ($stable(own_l_vec) && $stable(own_r_vec)));

  a_r8_illegal_r_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_r && !wev_l) |=> ($stable(own_l_vec) && $stable(own_r_vec)));

  a_r8_err_l_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    l_err |=> !l_err);

  a_r8_err_r_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    r_err |=> !r_err);
endmodule

bind sem_flag_bank sem_flag_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .own_l_vec(own_l_vec), .own_r_vec(own_r_vec),
  .ill_l(ill_l), .ill_r(ill_r), .wev_l(wev_l), .wev_r(wev_r),
  .wbit_l(wbit_l), .wbit_r(wbit_r), .sel_l(sel_l), .sel_r(sel_r),
  .l_err(l_err), .r_err(r_err), .l_dout(l_dout), .r_dout(r_dout));

// File: tb/sem_flag_bank_test.sv
module sem_flag_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        l_cs_n = 1, l_sem_n = 1, l_rw = 1, l_oe_n = 1;
  logic [1:0]  l_be_n = 2'b00;
  logic [12:0] l_addr = '0;
  logic [15:0] l_din = '0, l_dout;
  logic        l_err;
  logic        r_cs_n = 1, r_sem_n = 1, r_rw = 1, r_oe_n = 1;
  logic [1:0]  r_be_n = 2'b00;
  logic [12:0] r_addr = '0;
  logic [15:0] r_din = '0, r_dout;
  logic        r_err;

  int tests = 0, fails = 0;

  sem_flag_bank uut (.*);

  typedef struct {
    bit          right;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  event  sample_ev;

  // Monitor: pops the oldest expectation when a read is ready.
  initial forever begin
    @(sample_ev);
    if (sbq.size() != 0) begin
      item_t it;
      logic [15:0] act;
      it  = sbq.pop_front();
      act = it.right ? r_dout : l_dout;
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: %s port got %h expected %h", it.tag,
                 it.right ? "right" : "left", act, it.exp);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sem_n = 1; l_cs_n = 1; l_rw = 1; l_oe_n = 1; l_be_n = 2'b00;
    r_sem_n = 1; r_cs_n = 1; r_rw = 1; r_oe_n = 1; r_be_n = 2'b00;
  endtask

  // Driver for reads: expected flag view, replicated on 16 bits.
  task automatic rd(input bit right, input logic [12:0] a,
                    input bit view, input string tag);
    @(negedge clk);
    if (right) begin r_sem_n = 0; r_cs_n = 1; r_rw = 1; r_oe_n = 0; r_addr = a; end
    else       begin l_sem_n = 0; l_cs_n = 1; l_rw = 1; l_oe_n = 0; l_addr = a; end
    sbq.push_back('{right, {16{view}}, tag});
    #1 -> sample_ev;
    #1 idle();
  endtask

  // Write with optional participation of each port; rising rw captures.
  task automatic wr(input bit use_l, input logic [12:0] la, input logic [15:0] ld,
                    input bit use_r, input logic [12:0] ra, input logic [15:0] rdat);
    @(negedge clk);
    if (use_l) begin l_sem_n = 0; l_cs_n = 1; l_rw = 0; l_addr = la; l_din = ld; end
    if (use_r) begin r_sem_n = 0; r_cs_n = 1; r_rw = 0; r_addr = ra; r_din = rdat; end
    @(negedge clk);
    if (use_l) l_rw = 1;
    if (use_r) r_rw = 1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int f = 0; f < 8; f++) begin
      rd(0, 13'(f), 1, "R1 reset left");
      rd(1, 13'(f), 1, "R1 reset right");
    end
    check("R1 l_err reset", {15'd0, l_err}, 16'd0);
    check("R1 r_err reset", {15'd0, r_err}, 16'd0);
    // R3 gating: output enable high gives zeros
    @(negedge clk);
    l_sem_n = 0; l_rw = 1; l_oe_n = 1;
    #1 check("R3 oe high left dout", l_dout, 16'h0000);
    idle();
    // R2 left requests flag 2
    wr(1, 13'd2, 16'h0000, 0, 0, 0);
    rd(0, 13'd2, 0, "R2 owner left reads 0");
    rd(1, 13'd2, 1, "R2 other right reads 1");
    // R4 right requests while left owns
    wr(0, 0, 0, 1, 13'd2, 16'h0000);
    rd(1, 13'd2, 1, "R4 pending right reads 1");
    rd(0, 13'd2, 0, "R4 left still owner");
    // R5 left releases, right takes over
    wr(1, 13'd2, 16'h0001, 0, 0, 0);
    rd(1, 13'd2, 0, "R5 right now owner");
    rd(0, 13'd2, 1, "R5 left released");
    wr(0, 0, 0, 1, 13'd2, 16'h0001);
    rd(1, 13'd2, 1, "R5 right released");
    rd(0, 13'd2, 1, "R5 flag free left");
    // R6 same-cycle tie on flag 5
    wr(1, 13'd5, 16'h0000, 1, 13'd5, 16'h0000);
    rd(0, 13'd5, 0, "R6 left wins tie");
    rd(1, 13'd5, 1, "R6 right pending");
    wr(1, 13'd5, 16'h0001, 0, 0, 0);
    rd(1, 13'd5, 0, "R6 pending right granted");
    wr(0, 0, 0, 1, 13'd5, 16'h0001);
    // R7 upper address bits and upper data bits ignored; flags independent
    wr(1, 13'h1FF9, 16'hFFFE, 0, 0, 0);
    rd(0, 13'd1, 0, "R7 addr 1FF9 selects flag 1");
    rd(0, 13'd0, 1, "R7 flag 0 untouched");
    rd(1, 13'h0F01, 1, "R7 right view flag 1");
    wr(1, 13'd1, 16'hFFFF, 0, 0, 0);
    rd(0, 13'd1, 1, "R7 release with bit0=1");
    // R7 no rising edge: rw held high with access asserted
    @(negedge clk);
    l_sem_n = 0; l_rw = 1; l_oe_n = 1; l_addr = 13'd3; l_din = 16'h0000;
    @(negedge clk); @(negedge clk);
    idle();
    rd(0, 13'd3, 1, "R7 no edge no write");
    // R8 illegal access on left, flag 6
    @(negedge clk);
    l_cs_n = 0; l_sem_n = 0; l_be_n = 2'b10; l_rw = 0; l_addr = 13'd6; l_din = 0;
    @(negedge clk);
    check("R8 l_err pulse high", {15'd0, l_err}, 16'd1);
    l_rw = 1;
    @(negedge clk);
    check("R8 l_err pulse one cycle", {15'd0, l_err}, 16'd0);
    idle();
    rd(0, 13'd6, 1, "R8 no change left");
    rd(1, 13'd6, 1, "R8 no change right");
    // R8 both byte enables high: no error
    @(negedge clk);
    r_cs_n = 0; r_sem_n = 0; r_be_n = 2'b11; r_rw = 0; r_addr = 13'd6;
    @(negedge clk);
    check("R8 no err with be high", {15'd0, r_err}, 16'd0);
    r_rw = 1;
    @(negedge clk);
    idle();
    rd(1, 13'd6, 1, "R8 be high no change");
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule